// File: doc/BRIEF.md
# Power-Save Mode and Wake Controller

This block puts a processor into one of two power-save modes and brings it back out. A one-cycle request with a mode select moves the block from normal running into either a light mode, where only the CPU clock is stopped while peripherals and the clock source keep running, or a deep mode, where the peripheral and oscillator clocks are stopped as well. While in either mode the block watches three kinds of wake source: qualified interrupt requests, non-power-on reset events and a watchdog timeout. Each wake is recorded in sticky status bits that software clears by writing zeros.

Leaving the light mode is immediate. Leaving the deep mode re-enables the oscillator and counts a start-up window on an always-on slow tick enable. When the PLL is in use, a second lock window follows. At the end of the window the oscillator-ready input is checked. If the clock is good, the CPU is released. If it is not good and the fail-safe monitor is enabled, a trap is raised and the backup RC clock is selected. If it is not good and the monitor is off, the CPU stays halted until the oscillator reports ready.

Top module: `pwrsave_ctrl`

## Requirements
- R1: In the light mode `cpu_clk_en` is 0 while `periph_clk_en` and `osc_en` stay 1.
- R2: In the deep mode `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R3: An interrupt line wakes the block only when its request and enable are both 1 and its 3-bit priority is strictly greater than `cpu_ipl`. A line that is disabled or that has a priority equal to the level does not wake it.
- R4: A pulse on either bit of `rst_evt` wakes the block from either mode and sets the status bit of the mode that was active. The power-on reset `rst_n` clears all status bits.
- R5: `wdt_timeout` wakes the block only while `wdt_en` is 1. It then sets both the mode status bit and `status_wdto`.
- R6: On a light-mode exit, `cpu_clk_en` returns to 1 at the same clock edge that raises `wake_pulse`.
- R7: On a deep-mode exit, the CPU stays halted for OST_TICKS `lprc_tick` pulses. When `pll_en` is 1, it stays halted for a further PLL_TICKS pulses.
- R8: At the end of the deep-exit window there are three outcomes. With `osc_ready`=1 the CPU is released and `use_backup_rc` is cleared. With `osc_ready`=0 and `fscm_en`=1, a one-cycle `clk_fail_trap` is raised, `use_backup_rc` is set and the CPU is released. With `osc_ready`=0 and `fscm_en`=0, the CPU stays halted until `osc_ready` is 1.
- R9: The status bits are sticky. A cycle with `stat_we`=1 clears each bit whose `stat_wdata` bit is 0 and keeps each bit whose `stat_wdata` bit is 1. The bit positions are 0 for the deep mode, 1 for the light mode and 2 for the watchdog.
- R10: Each wake gives a one-cycle `wake_pulse` and loads `wake_cause`, which holds until the next wake. Its bits are 0 for an interrupt, 1 for the watchdog and 2 for a reset.
- R11: `isr_branch` pulses for one cycle in the cycle the CPU clock is re-enabled, and only when the wake included an interrupt and no reset.
- R12: `fscm_active` follows `fscm_en` in running, in the light mode and in the exit waits, and is 0 in the deep mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| ps_req | input | 1 | Power-save request pulse |
| ps_mode | input | 1 | Mode select: 0 light, 1 deep |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Interrupt enables |
| irq_prio | input | N_IRQ*PRIO_W | Per-line priorities, line i at bits [i*PRIO_W +: PRIO_W] |
| cpu_ipl | input | PRIO_W | Current CPU priority level |
| rst_evt | input | RST_W | Non-power-on reset events (brown-out, reset pin) |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog timeout |
| lprc_tick | input | 1 | Always-on slow clock enable |
| osc_ready | input | 1 | Oscillator reports a valid clock |
| pll_en | input | 1 | PLL in use, adds the lock window |
| fscm_en | input | 1 | Fail-safe clock monitor enable |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 3 | Status write data, 0 clears a bit |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Primary oscillator enable |
| use_backup_rc | output | 1 | Backup RC clock selected |
| clk_fail_trap | output | 1 | Clock-failure trap pulse |
| fscm_active | output | 1 | Fail-safe monitor running |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_cause | output | 3 | Registered wake cause |
| isr_branch | output | 1 | Branch-to-service-routine pulse |
| status_sleep | output | 1 | Deep-mode wake status |
| status_idle | output | 1 | Light-mode wake status |
| status_wdto | output | 1 | Watchdog wake status |

## Verification
A controller that is stuck in the wrong state shows on the three clock enables in the first sampled cycle after the fault, because those enables decode the state directly. A wrong wake qualification shows in the cycle after the stimulus as a missing or extra `wake_pulse` and a wrong `wake_cause`. A start-up counter that runs off by one moves the rising edge of `cpu_clk_en` by exactly one cycle when the tick enable is held high, so the bench counts the halted cycles exactly. A status register that drops or invents a bit is visible at its ports until the next software write.

// File: rtl/pwrsave_pkg.sv
package pwrsave_pkg;

   typedef enum logic [2:0] {
      PS_RUN   = 3'd0,
      PS_IDLE  = 3'd1,
      PS_SLEEP = 3'd2,
      PS_OSCW  = 3'd3,
      PS_PLLW  = 3'd4,
      PS_HOLD  = 3'd5
   } ps_state_e;

   localparam int unsigned CAUSE_W   = 3;
   localparam int unsigned CAUSE_IRQ = 0;
   localparam int unsigned CAUSE_WDT = 1;
   localparam int unsigned CAUSE_RST = 2;

   // bit 0 deep mode, bit 1 light mode, bit 2 watchdog
   typedef struct packed {
      logic wdto;
      logic idle;
      logic sleep;
   } ps_status_t;

endpackage

// File: rtl/pwrsave_wake_detect.sv
module pwrsave_wake_detect
   import pwrsave_pkg::*;
#(
   parameter int unsigned N_IRQ  = 4,
   parameter int unsigned PRIO_W = 3,
   parameter int unsigned RST_W  = 2
) (
   input  logic [N_IRQ-1:0]        irq_req,
   input  logic [N_IRQ-1:0]        irq_en,
   input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
   input  logic [PRIO_W-1:0]       cpu_ipl,
   input  logic [RST_W-1:0]        rst_evt,
   input  logic                    wdt_en,
   input  logic                    wdt_timeout,
   output logic [CAUSE_W-1:0]      cause
);

   logic [N_IRQ-1:0] line_hit;

   for (genvar i = 0; i < N_IRQ; i++) begin : g_line
      assign line_hit[i] = irq_req[i] & irq_en[i] &
                           (irq_prio[i*PRIO_W +: PRIO_W] > cpu_ipl);
   end

   always_comb begin
      cause            = '0;
      cause[CAUSE_IRQ] = |line_hit;
      cause[CAUSE_WDT] = wdt_en & wdt_timeout;
      cause[CAUSE_RST] = |rst_evt;
   end

endmodule

// File: rtl/pwrsave_startup_timer.sv
module pwrsave_startup_timer #(
   parameter int unsigned TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   output logic done
);

   localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS);

   if (TICKS < 1) begin : g_bad_ticks
      $error("pwrsave_startup_timer: TICKS must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign done = en && tick && (cnt == CW'(TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!en || done)   cnt <= '0;
      else if (tick)          cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/pwrsave_status.sv
module pwrsave_status
   import pwrsave_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  ps_status_t set_bits,
   input  logic       we,
   input  ps_status_t wdata,
   output ps_status_t q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & (we ? wdata : ps_status_t'('1))) | set_bits;
   end

endmodule

// File: rtl/pwrsave_ctrl.sv
module pwrsave_ctrl
   import pwrsave_pkg::*;
#(
   parameter int unsigned N_IRQ     = 4,
   parameter int unsigned PRIO_W    = 3,
   parameter int unsigned RST_W     = 2,
   parameter int unsigned OST_TICKS = 8,
   parameter int unsigned PLL_TICKS = 4,
   parameter bit          HAS_PLL   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ps_req,
   input  logic                    ps_mode,
   input  logic [N_IRQ-1:0]        irq_req,
   input  logic [N_IRQ-1:0]        irq_en,
   input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
   input  logic [PRIO_W-1:0]       cpu_ipl,
   input  logic [RST_W-1:0]        rst_evt,
   input  logic                    wdt_en,
   input  logic                    wdt_timeout,
   input  logic                    lprc_tick,
   input  logic                    osc_ready,
   input  logic                    pll_en,
   input  logic                    fscm_en,
   input  logic                    stat_we,
   input  logic [2:0]              stat_wdata,
   output logic                    cpu_clk_en,
   output logic                    periph_clk_en,
   output logic                    osc_en,
   output logic                    use_backup_rc,
   output logic                    clk_fail_trap,
   output logic                    fscm_active,
   output logic                    wake_pulse,
   output logic [2:0]              wake_cause,
   output logic                    isr_branch,
   output logic                    status_sleep,
   output logic                    status_idle,
   output logic                    status_wdto
);

   if (N_IRQ < 1)  begin : g_bad_nirq  $error("pwrsave_ctrl: N_IRQ < 1");  end
   if (PRIO_W < 1) begin : g_bad_prio  $error("pwrsave_ctrl: PRIO_W < 1"); end
   if (RST_W < 1)  begin : g_bad_rst   $error("pwrsave_ctrl: RST_W < 1");  end

   ps_state_e            state, nstate;
   logic [CAUSE_W-1:0]   cause_now;
   logic                 in_mode, wake_now;
   logic                 ost_done, pll_done, pll_go;
   logic                 check_now, release_now;
   logic                 isr_pend, isr_pend_eff;
   ps_status_t           st_set, st_q;

   pwrsave_wake_detect #(
      .N_IRQ (N_IRQ),
      .PRIO_W(PRIO_W),
      .RST_W (RST_W)
   ) i_detect (
      .irq_req    (irq_req),
      .irq_en     (irq_en),
      .irq_prio   (irq_prio),
      .cpu_ipl    (cpu_ipl),
      .rst_evt    (rst_evt),
      .wdt_en     (wdt_en),
      .wdt_timeout(wdt_timeout),
      .cause      (cause_now)
   );

   assign in_mode  = (state == PS_IDLE) || (state == PS_SLEEP);
   assign wake_now = in_mode && (|cause_now);

   pwrsave_startup_timer #(.TICKS(OST_TICKS)) i_ost (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (state == PS_OSCW),
      .tick (lprc_tick),
      .done (ost_done)
   );

   if (HAS_PLL) begin : g_pll
      pwrsave_startup_timer #(.TICKS(PLL_TICKS)) i_lock (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (state == PS_PLLW),
         .tick (lprc_tick),
         .done (pll_done)
      );
      assign pll_go = pll_en;
   end else begin : g_no_pll
      assign pll_done = 1'b0;
      assign pll_go   = 1'b0;
   end

   assign check_now = ((state == PS_OSCW) && ost_done && !pll_go) ||
                      ((state == PS_PLLW) && pll_done);

   always_comb begin
      nstate = state;
      unique case (state)
         PS_RUN:   if (ps_req)   nstate = ps_mode ? PS_SLEEP : PS_IDLE;
         PS_IDLE:  if (wake_now) nstate = PS_RUN;
         PS_SLEEP: if (wake_now) nstate = PS_OSCW;
         PS_OSCW:  if (ost_done) begin
                      if (pll_go)                      nstate = PS_PLLW;
                      else if (osc_ready || fscm_en)   nstate = PS_RUN;
                      else                             nstate = PS_HOLD;
                   end
         PS_PLLW:  if (pll_done) nstate = (osc_ready || fscm_en) ? PS_RUN : PS_HOLD;
         PS_HOLD:  if (osc_ready) nstate = PS_RUN;
         default:  nstate = PS_RUN;
      endcase
   end

   assign release_now  = (nstate == PS_RUN) && (state != PS_RUN);
   assign isr_pend_eff = wake_now ? (cause_now[CAUSE_IRQ] && !cause_now[CAUSE_RST])
                                  : isr_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= PS_RUN;
         wake_pulse    <= 1'b0;
         wake_cause    <= '0;
         isr_pend      <= 1'b0;
         isr_branch    <= 1'b0;
         clk_fail_trap <= 1'b0;
         use_backup_rc <= 1'b0;
      end else begin
         state         <= nstate;
         wake_pulse    <= wake_now;
         isr_pend      <= release_now ? 1'b0 : isr_pend_eff;
         isr_branch    <= release_now && isr_pend_eff;
         clk_fail_trap <= check_now && !osc_ready && fscm_en;
         if (wake_now) wake_cause <= cause_now;
         if (check_now && !osc_ready && fscm_en) use_backup_rc <= 1'b1;
         else if (check_now && osc_ready)        use_backup_rc <= 1'b0;
      end
   end

   always_comb begin
      st_set       = '0;
      st_set.sleep = wake_now && (state == PS_SLEEP);
      st_set.idle  = wake_now && (state == PS_IDLE);
      st_set.wdto  = wake_now && cause_now[CAUSE_WDT];
   end

   pwrsave_status i_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_bits(st_set),
      .we      (stat_we),
      .wdata   (ps_status_t'(stat_wdata)),
      .q       (st_q)
   );

   assign cpu_clk_en    = (state == PS_RUN);
   assign periph_clk_en = (state != PS_SLEEP);
   assign osc_en        = (state != PS_SLEEP);
   assign fscm_active   = fscm_en && (state != PS_SLEEP);
   assign status_sleep  = st_q.sleep;
   assign status_idle   = st_q.idle;
   assign status_wdto   = st_q.wdto;

endmodule

// File: rtl/pwrsave_ctrl_chk.sv
module pwrsave_ctrl_chk
   import pwrsave_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input ps_state_e  state,
   input logic       cpu_clk_en,
   input logic       osc_en,
   input logic       osc_ready,
   input logic       fscm_en,
   input logic       wake_pulse,
   input logic [2:0] wake_cause,
   input logic       clk_fail_trap,
   input logic       use_backup_rc,
   input logic       isr_branch,
   input logic       status_sleep,
   input logic       status_idle,
   input logic       status_wdto
);

   // R7
   osc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_en) |-> !cpu_clk_en);

   // R8
   release_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_clk_en) |-> ($past(state) == PS_IDLE) || $past(osc_ready) || use_backup_rc);

   // R8
   trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_fail_trap |-> use_backup_rc && $past(fscm_en) && !$past(osc_ready));

   // R6
   idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == PS_IDLE && state != PS_IDLE) |-> cpu_clk_en && wake_pulse);

   // R10
   wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (wake_cause != 3'b000));

   // R10
   wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   // R5
   wdto_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_wdto) |-> status_sleep || status_idle);

   // R11
   isr_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      isr_branch |-> cpu_clk_en && wake_cause[0] && !wake_cause[2]);

endmodule

bind pwrsave_ctrl pwrsave_ctrl_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .state        (state),
   .cpu_clk_en   (cpu_clk_en),
   .osc_en       (osc_en),
   .osc_ready    (osc_ready),
   .fscm_en      (fscm_en),
   .wake_pulse   (wake_pulse),
   .wake_cause   (wake_cause),
   .clk_fail_trap(clk_fail_trap),
   .use_backup_rc(use_backup_rc),
   .isr_branch   (isr_branch),
   .status_sleep (status_sleep),
   .status_idle  (status_idle),
   .status_wdto  (status_wdto)
);

// File: tb/test_pwrsave_ctrl.sv
`timescale 1ns/1ps
module test_pwrsave_ctrl;

   localparam int unsigned N_IRQ  = 4;
   localparam int unsigned PRIO_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ps_req = 1'b0, ps_mode = 1'b0;
   logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
   logic [N_IRQ*PRIO_W-1:0] irq_prio = '0;
   logic [PRIO_W-1:0] cpu_ipl = 3'd2;
   logic [1:0] rst_evt = '0;
   logic wdt_en = 1'b0, wdt_timeout = 1'b0;
   logic lprc_tick = 1'b1, osc_ready = 1'b1, pll_en = 1'b0, fscm_en = 1'b0;
   logic stat_we = 1'b0;
   logic [2:0] stat_wdata = '0;
   logic cpu_clk_en, periph_clk_en, osc_en, use_backup_rc, clk_fail_trap;
   logic fscm_active, wake_pulse, isr_branch;
   logic [2:0] wake_cause;
   logic status_sleep, status_idle, status_wdto;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   pwrsave_ctrl i_pwrsave_ctrl (
      .clk(clk), .rst_n(rst_n), .ps_req(ps_req), .ps_mode(ps_mode),
      .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio), .cpu_ipl(cpu_ipl),
      .rst_evt(rst_evt), .wdt_en(wdt_en), .wdt_timeout(wdt_timeout),
      .lprc_tick(lprc_tick), .osc_ready(osc_ready), .pll_en(pll_en), .fscm_en(fscm_en),
      .stat_we(stat_we), .stat_wdata(stat_wdata),
      .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
      .use_backup_rc(use_backup_rc), .clk_fail_trap(clk_fail_trap),
      .fscm_active(fscm_active), .wake_pulse(wake_pulse), .wake_cause(wake_cause),
      .isr_branch(isr_branch), .status_sleep(status_sleep),
      .status_idle(status_idle), .status_wdto(status_wdto)
   );

   // src: 0 interrupt, 1 watchdog, 2 reset event; path: 0 good clock, 1 backup, 2 hold
   typedef struct packed {
      logic       mode;
      logic [1:0] src;
      logic       osc;
      logic       fscm;
      logic       pll;
      logic [2:0] st;
      logic [2:0] cause;
      logic       isr;
      logic [1:0] path;
      logic       backup;
      logic [7:0] dly;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 3'b010, 3'b001, 1'b1, 2'd0, 1'b0, 8'd0},
      '{1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 3'b110, 3'b010, 1'b0, 2'd0, 1'b0, 8'd0},
      '{1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 3'b010, 3'b100, 1'b0, 2'd0, 1'b0, 8'd0},
      '{1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'b001, 3'b001, 1'b1, 2'd0, 1'b0, 8'd8},
      '{1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 3'b001, 3'b001, 1'b1, 2'd0, 1'b0, 8'd12},
      '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 3'b101, 3'b010, 1'b0, 2'd0, 1'b0, 8'd8},
      '{1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 3'b001, 3'b100, 1'b0, 2'd1, 1'b1, 8'd8},
      '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 3'b001, 3'b001, 1'b1, 2'd2, 1'b1, 8'd40},
      '{1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 3'b001, 3'b001, 1'b1, 2'd0, 1'b0, 8'd8}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] st_now();
      return {status_wdto, status_idle, status_sleep};
   endfunction

   task automatic enter_mode(input logic m);
      @(negedge clk); ps_req = 1'b1; ps_mode = m;
      @(negedge clk); ps_req = 1'b0;
   endtask

   task automatic write_status(input logic [2:0] d);
      @(negedge clk); stat_we = 1'b1; stat_wdata = d;
      @(negedge clk); stat_we = 1'b0;
   endtask

   task automatic wait_cpu();
      for (int k = 0; k < 100 && !cpu_clk_en; k++) @(negedge clk);
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      int cnt;
      write_status(3'b000);
      osc_ready = v.osc; fscm_en = v.fscm; pll_en = v.pll;
      enter_mode(v.mode);
      if (v.mode) begin
         // R2
         chk("R2", $sformatf("v%0d deep gating", idx),
             {cpu_clk_en, periph_clk_en, osc_en}, 3'b000);
      end else begin
         // R1
         chk("R1", $sformatf("v%0d light gating", idx),
             {cpu_clk_en, periph_clk_en, osc_en}, 3'b011);
      end
      case (v.src)
         2'd0: begin irq_req[1] = 1'b1; irq_en[1] = 1'b1; irq_prio[5:3] = 3'd5; end
         2'd1: begin wdt_en = 1'b1; wdt_timeout = 1'b1; end
         default: rst_evt = 2'b01;
      endcase
      @(negedge clk);
      irq_req = '0; irq_en = '0; wdt_timeout = 1'b0; wdt_en = 1'b0; rst_evt = '0;
      // R10
      chk("R10", $sformatf("v%0d wake pulse", idx), wake_pulse, 1'b1);
      chk("R10", $sformatf("v%0d wake cause", idx), wake_cause, v.cause);
      cnt = 0;
      while (!cpu_clk_en && cnt < 100) begin
         cnt++;
         if (v.path == 2'd2 && cnt == 40) osc_ready = 1'b1;
         @(negedge clk);
      end
      // R6 R7 R8
      chk(v.mode ? "R7" : "R6", $sformatf("v%0d halted cycles", idx), cnt, v.dly);
      chk("R8", $sformatf("v%0d trap", idx), clk_fail_trap, v.path == 2'd1);
      chk("R8", $sformatf("v%0d backup", idx), use_backup_rc, v.backup);
      // R11
      chk("R11", $sformatf("v%0d isr branch", idx), isr_branch, v.isr);
      // R4 R5
      chk(v.src == 2'd1 ? "R5" : "R4", $sformatf("v%0d status", idx), st_now(), v.st);
      @(negedge clk);
      chk("R10", $sformatf("v%0d pulse ends, cause held", idx),
          {wake_pulse, wake_cause}, {1'b0, v.cause});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4 reset state
      chk("R4", "reset enables", {cpu_clk_en, periph_clk_en, osc_en}, 3'b111);
      chk("R4", "reset status", st_now(), 3'b000);
      chk("R10", "reset pulse", {wake_pulse, isr_branch, clk_fail_trap, use_backup_rc}, 4'b0000);

      for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

      // R3 and R12 in light mode
      fscm_en = 1'b1;
      @(negedge clk);
      chk("R12", "monitor in run", fscm_active, 1'b1);
      enter_mode(1'b0);
      irq_req[1] = 1'b1; irq_en[1] = 1'b1; irq_prio[5:3] = 3'd2; cpu_ipl = 3'd2;
      repeat (3) @(negedge clk);
      chk("R3", "equal priority ignored", {cpu_clk_en, wake_pulse}, 2'b00);
      chk("R12", "monitor in light mode", fscm_active, 1'b1);
      irq_prio[5:3] = 3'd5; irq_en[1] = 1'b0;
      repeat (3) @(negedge clk);
      chk("R3", "disabled line ignored", {cpu_clk_en, wake_pulse}, 2'b00);
      irq_en[1] = 1'b1;
      @(negedge clk);
      irq_req = '0; irq_en = '0;
      chk("R3", "qualified line wakes", {cpu_clk_en, wake_pulse}, 2'b11);

      // R5 watchdog ignored when disabled, R12 in deep mode
      enter_mode(1'b1);
      chk("R12", "monitor in deep mode", fscm_active, 1'b0);
      wdt_en = 1'b0; wdt_timeout = 1'b1;
      repeat (3) @(negedge clk);
      chk("R5", "disabled watchdog ignored", {osc_en, cpu_clk_en}, 2'b00);
      wdt_timeout = 1'b0;
      rst_evt = 2'b10;
      @(negedge clk);
      rst_evt = '0;
      chk("R4", "reset pin wakes deep mode", wake_cause, 3'b100);
      wait_cpu();
      fscm_en = 1'b0;

      // R9 sticky status and masked clear
      write_status(3'b000);
      enter_mode(1'b0);
      wdt_en = 1'b1; wdt_timeout = 1'b1;
      @(negedge clk);
      wdt_en = 1'b0; wdt_timeout = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9", "sticky after wake", st_now(), 3'b110);
      write_status(3'b011);
      chk("R9", "write clears watchdog only", st_now(), 3'b010);
      repeat (3) @(negedge clk);
      chk("R9", "kept bit stays", st_now(), 3'b010);
      write_status(3'b000);
      chk("R9", "write zero clears all", st_now(), 3'b000);

      // R4 power-on reset clears status
      enter_mode(1'b0);
      rst_evt = 2'b01;
      @(negedge clk);
      rst_evt = '0;
      chk("R4", "reset event sets light bit", st_now(), 3'b010);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4", "power-on clears status", st_now(), 3'b000);
      chk("R4", "power-on enables", {cpu_clk_en, periph_clk_en, osc_en}, 3'b111);

      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule